// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a block-wide lower-level memory. The processor issues word reads and writes on a valid/ready request channel. Each request address is split three ways. The low bits select a byte within a 32-byte line. The next bits pick one set. The remaining high bits are the tag. The two stored tags of the chosen set are compared with the request tag at the same time. The hit flag is the OR of the two per-way matches, and the match of way 1 steers the data multiplexer. A hit is accepted in the cycle it is presented, and its response comes out one cycle later.

On a miss the request stays stalled. A single least-recently-used bit per set names the victim way. The controller moves through four states. ST_LOOKUP compares tags and accepts hits. On a miss it goes to ST_EVICT if the victim is valid and dirty, otherwise to ST_FETCH. ST_EVICT offers the whole victim line as a memory write and moves to ST_FETCH once the memory accepts it. ST_FETCH offers a block read and moves to ST_REFILL once it is accepted. ST_REFILL waits for the read data, installs the line with its tag (valid, clean), and returns to ST_LOOKUP. There the held request now hits and completes, and a write merges its word into the freshly installed line.

Top module: `cache_2way`

## Requirements
- R1: After reset every line is invalid, `resp_valid`, `mem_req_valid` and `req_ready` are low, and the first access to any block misses.
- R2: A request that hits is accepted (`req_ready` high) in the cycle it is presented. Exactly one cycle after each acceptance `resp_valid` is high for one cycle, and for a read `resp_rdata` carries the addressed word.
- R3: A block resident in either way of a set hits. Two blocks with the same index and different tags can both be resident, and each returns its own data.
- R4: Address bits [4:0] are the byte offset, bits [4:2] select one of eight 32-bit words, the next log2(SETS) bits are the set index, and all higher bits are the tag. Other words of an already fetched line hit.
- R5: A miss reads the whole 256-bit line with a block-aligned `mem_req_addr` (low 5 bits zero). Word k of a line occupies bits [32k+31:32k] of the memory data.
- R6: The victim of a miss is the way in its set that was not used by the most recent hit or refill of that set.
- R7: A write hit changes only the cached copy and causes no memory traffic. A later read returns the new word.
- R8: Evicting a dirty line first issues a memory write (`mem_req_write`=1) of the full line at its own block address, and only then the block read.
- R9: Evicting a clean or invalid line issues no memory write.
- R10: A write miss fetches the line, then merges the written word. The other words keep their memory values.
- R11: `req_ready` stays low from the miss until the line is installed, and in particular whenever `mem_req_valid` is high.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, direction and write data are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| resp_valid | output | 1 | Completion, one cycle after acceptance |
| resp_rdata | output | 32 | Read data of the completed read |
| mem_req_valid | output | 1 | Memory block request present |
| mem_req_write | output | 1 | 1 = block write-back, 0 = block read |
| mem_req_addr | output | 32 | Block-aligned memory address |
| mem_req_wdata | output | 256 | Line being written back |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Block read data present |
| mem_rsp_rdata | input | 256 | Block read data |

## Verification
The hardest case to reach is a dirty victim whose eviction is decided by the LRU bit. Doing so needs two distinct tags resident in one set, a write hit on one of them, and a touch order that leaves that dirty line as least recently used when a third tag maps to the same set. A directed sequence on set 0 builds exactly that order. A random phase then confines traffic to four tags over four sets, which forces frequent conflict evictions, dirty and clean. A bench model keeps a recency-ordered list of lines per set and a block memory, and predicts for every access whether it hits, any write-back with its data, and the read address and returned word. The memory responder withholds ready for one cycle on every request to exercise the hold rule.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_EVICT,
        ST_FETCH,
        ST_REFILL
    } cache_state_e;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match
    import cache_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic [TAG_W-1:0]    way_tag [NUM_WAYS],
    input  logic [NUM_WAYS-1:0] way_valid,
    input  logic [TAG_W-1:0]    req_tag,
    output logic [NUM_WAYS-1:0] match,
    output logic                hit,
    output logic                sel
);
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tag[g] == req_tag);
    end

    assign hit = |match;
    assign sel = match[1];
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
    parameter int SETS  = 8,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             victim,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way
);
    logic [SETS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else if (touch) begin
            older_q[touch_idx] <= ~touch_way;
        end
    end

    assign victim = older_q[look_idx];
endmodule

// File: rtl/cache_2way.sv
module cache_2way
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BLOCK_BYTES = 32,
    parameter int SETS        = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     resp_valid,
    output logic [DATA_W-1:0]        resp_rdata,
    output logic                     mem_req_valid,
    output logic                     mem_req_write,
    output logic [ADDR_W-1:0]        mem_req_addr,
    output logic [BLOCK_BYTES*8-1:0] mem_req_wdata,
    input  logic                     mem_req_ready,
    input  logic                     mem_rsp_valid,
    input  logic [BLOCK_BYTES*8-1:0] mem_rsp_rdata
);
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int BYTE_W  = $clog2(DATA_W / 8);
    localparam int BLOCK_W = BLOCK_BYTES * 8;
    localparam int WORDS   = BLOCK_W / DATA_W;
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;

    cache_state_e st_q, st_d;

    logic [BLOCK_W-1:0] data_q  [NUM_WAYS][SETS];
    logic [TAG_W-1:0]   tag_q   [NUM_WAYS][SETS];
    logic [SETS-1:0]    valid_q [NUM_WAYS];
    logic [SETS-1:0]    dirty_q [NUM_WAYS];

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_wsel = req_addr[BYTE_W +: WSEL_W];

    logic [TAG_W-1:0]    look_tag [NUM_WAYS];
    logic [NUM_WAYS-1:0] look_valid;
    logic [NUM_WAYS-1:0] way_match;
    logic                way_hit;
    logic                way_sel;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_look
        assign look_tag[w]   = tag_q[w][req_idx];
        assign look_valid[w] = valid_q[w][req_idx];
    end

    cache_tag_match #(.TAG_W(TAG_W)) u_match (
        .way_tag   (look_tag),
        .way_valid (look_valid),
        .req_tag   (req_tag),
        .match     (way_match),
        .hit       (way_hit),
        .sel       (way_sel)
    );

    logic [BLOCK_W-1:0] hit_line;
    logic [DATA_W-1:0]  hit_word;
    assign hit_line = data_q[way_sel][req_idx];
    assign hit_word = hit_line[req_wsel*DATA_W +: DATA_W];

    // Miss context, captured when leaving ST_LOOKUP
    logic [IDX_W-1:0] mis_idx;
    logic [TAG_W-1:0] mis_tag;
    logic             mis_way;
    logic             victim_way;

    logic accept;
    logic fill_done;
    assign accept    = req_valid && req_ready;
    assign fill_done = (st_q == ST_REFILL) && mem_rsp_valid;

    cache_lru #(.SETS(SETS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (req_idx),
        .victim    (victim_way),
        .touch     (accept || fill_done),
        .touch_idx (fill_done ? mis_idx : req_idx),
        .touch_way (fill_done ? mis_way : way_sel)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOOKUP;
        else        st_q <= st_d;
    end

    // Next state and outputs
    always_comb begin
        st_d          = st_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = {mis_tag, mis_idx, {OFF_W{1'b0}}};
        mem_req_wdata = data_q[mis_way][mis_idx];
        unique case (st_q)
            ST_LOOKUP: begin
                req_ready = req_valid && way_hit;
                if (req_valid && !way_hit) begin
                    if (valid_q[victim_way][req_idx] && dirty_q[victim_way][req_idx])
                        st_d = ST_EVICT;
                    else
                        st_d = ST_FETCH;
                end
            end
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {tag_q[mis_way][mis_idx], mis_idx, {OFF_W{1'b0}}};
                if (mem_req_ready) st_d = ST_FETCH;
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_d = ST_REFILL;
            end
            ST_REFILL: begin
                if (mem_rsp_valid) st_d = ST_LOOKUP;
            end
            default: st_d = ST_LOOKUP;
        endcase
    end

    // Line storage
    always_ff @(posedge clk) begin
        if (fill_done) begin
            data_q[mis_way][mis_idx] <= mem_rsp_rdata;
            tag_q[mis_way][mis_idx]  <= mis_tag;
        end else if (accept && req_write) begin
            data_q[way_sel][req_idx][req_wsel*DATA_W +: DATA_W] <= req_wdata;
        end
    end

    // Line state, miss context and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                valid_q[w] <= '0;
                dirty_q[w] <= '0;
            end
            mis_idx    <= '0;
            mis_tag    <= '0;
            mis_way    <= 1'b0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= accept;
            if (accept && !req_write) resp_rdata <= hit_word;
            if (st_q == ST_LOOKUP && req_valid && !way_hit) begin
                mis_idx <= req_idx;
                mis_tag <= req_tag;
                mis_way <= victim_way;
            end
            if (fill_done) begin
                valid_q[mis_way][mis_idx] <= 1'b1;
                dirty_q[mis_way][mis_idx] <= 1'b0;
            end else if (accept && req_write) begin
                dirty_q[way_sel][req_idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cache_2way_chk.sv
module cache_2way_chk #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [1:0]        match,
    input logic              hit
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);

    AST_READY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> hit);  // R2
    AST_MATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));  // R3
    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);  // R2
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready));  // R2
    AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));  // R5
    AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_req_ready) |=> (mem_req_valid && !mem_req_write));  // R8
    AST_STALL_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);  // R11
    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));  // R12
endmodule

bind cache_2way cache_2way_chk #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .match         (way_match),
    .hit           (way_hit)
);

// File: tb/tb_cache_2way.sv
module tb_cache_2way;
    localparam int NSETS = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_req_valid;
    logic         mem_req_write;
    logic [31:0]  mem_req_addr;
    logic [255:0] mem_req_wdata;
    logic         mem_req_ready = 1'b0;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_rdata = '0;

    always #2 clk = ~clk;  // 250 MHz

    cache_2way dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tg, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
        end
    endtask

    // Reference model: block memory plus a recency-ordered line list per set
    typedef struct packed {
        logic [26:0]  blk;
        logic [255:0] data;
        logic         dirty;
    } mline_t;

    mline_t       sets_m [NSETS][$];
    logic [255:0] mem_m [int unsigned];

    function automatic logic [255:0] mem_block(input logic [26:0] b);
        logic [255:0] v;
        if (mem_m.exists(int'(b))) return mem_m[int'(b)];
        for (int k = 0; k < 8; k++)
            v[k*32 +: 32] = 32'hC0DE0000 ^ ({5'd0, b} << 8) ^ (k << 2);
        return v;
    endfunction

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          input string tg);
        logic [26:0]  b;
        int           s, w, pos, cyc;
        bit           exp_hit, exp_wb, acc, wb_seen, rd_seen, rsp_pend, hold;
        logic [31:0]  exp_wb_addr, exp_rd_addr, exp_word, h_addr;
        logic [255:0] exp_wb_data, fill;
        logic         h_wr;
        mline_t       ln, vic;

        b = a[31:5]; s = int'(a[7:5]); w = int'(a[4:2]);
        pos = -1;
        foreach (sets_m[s][i]) if (sets_m[s][i].blk == b) pos = i;
        exp_hit = (pos >= 0); exp_wb = 0; exp_wb_addr = '0; exp_wb_data = '0;
        exp_rd_addr = {b, 5'd0}; fill = '0;
        if (exp_hit) begin
            ln = sets_m[s][pos];
            sets_m[s].delete(pos);
        end else begin
            if (sets_m[s].size() == 2) begin
                vic = sets_m[s].pop_back();
                if (vic.dirty) begin
                    exp_wb = 1; exp_wb_addr = {vic.blk, 5'd0}; exp_wb_data = vic.data;
                    mem_m[int'(vic.blk)] = vic.data;
                end
            end
            fill = mem_block(b);
            ln.blk = b; ln.data = fill; ln.dirty = 1'b0;
        end
        if (wr) begin
            ln.data[w*32 +: 32] = d; ln.dirty = 1'b1;
        end
        exp_word = ln.data[w*32 +: 32];
        sets_m[s].push_front(ln);

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cyc = 0; acc = 0; wb_seen = 0; rd_seen = 0; rsp_pend = 0; hold = 0;
        h_addr = '0; h_wr = 1'b0;
        while (!acc && cyc < 200) begin
            #1;
            mem_rsp_valid = rsp_pend;
            mem_rsp_rdata = rsp_pend ? fill : '0;
            rsp_pend = 0;
            mem_req_ready = 1'b0;
            if (req_ready) begin
                acc = 1;
                chk(exp_hit == (cyc == 0), tg, "hit/miss decision", 64'(cyc == 0), 64'(exp_hit));
            end
            if (mem_req_valid) begin
                chk(!req_ready, "R11", "ready during memory request", 64'(req_ready), 64'd0);
                if (!hold) begin
                    hold = 1; h_addr = mem_req_addr; h_wr = mem_req_write;
                end else begin
                    chk(mem_req_addr == h_addr && mem_req_write == h_wr, "R12",
                        "held memory request", 64'(mem_req_addr), 64'(h_addr));
                    mem_req_ready = 1'b1; hold = 0;
                    if (mem_req_write) begin
                        chk(exp_wb && !wb_seen && !rd_seen, exp_wb ? "R8" : (wr && exp_hit ? "R7" : "R9"),
                            "unexpected write-back", 64'(mem_req_addr), 64'(exp_wb_addr));
                        chk(mem_req_addr == exp_wb_addr, "R8", "write-back address",
                            64'(mem_req_addr), 64'(exp_wb_addr));
                        chk(mem_req_wdata == exp_wb_data, "R8", "write-back data",
                            mem_req_wdata[63:0], exp_wb_data[63:0]);
                        wb_seen = 1;
                    end else begin
                        chk(mem_req_addr == exp_rd_addr, "R5", "block read address",
                            64'(mem_req_addr), 64'(exp_rd_addr));
                        chk(wb_seen == exp_wb, "R8", "write-back before read",
                            64'(wb_seen), 64'(exp_wb));
                        rd_seen = 1; rsp_pend = 1;
                    end
                end
            end
            @(negedge clk);
            cyc++;
        end
        mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
        req_valid = 1'b0;
        chk(acc, "R11", "request completed after refill", 64'(acc), 64'd1);
        chk(rd_seen == !exp_hit, exp_hit ? (wr ? "R7" : "R2") : "R5", "block read issued",
            64'(rd_seen), 64'(!exp_hit));
        chk(wb_seen == exp_wb, exp_wb ? "R8" : "R9", "write-back issued",
            64'(wb_seen), 64'(exp_wb));
        #1;
        chk(resp_valid, "R2", "response valid", 64'(resp_valid), 64'd1);
        if (!wr) chk(resp_rdata == exp_word, tg, "read data", 64'(resp_rdata), 64'(exp_word));
        @(negedge clk);
        #1;
        chk(!resp_valid, "R2", "single-cycle response", 64'(resp_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        chk(!resp_valid, "R1", "resp_valid after reset", 64'(resp_valid), 64'd0);
        chk(!mem_req_valid, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        chk(!req_ready, "R1", "req_ready after reset", 64'(req_ready), 64'd0);

        access(0, 32'h0000_0100, '0, "R1");   // cold miss, way 0
        access(0, 32'h0000_0104, '0, "R4");   // other word of same line
        access(0, 32'h0000_011C, '0, "R4");   // last word of line
        access(0, 32'h0000_0200, '0, "R1");   // same set, new tag -> way 1
        access(0, 32'h0000_0100, '0, "R3");   // both resident
        access(0, 32'h0000_0204, '0, "R3");
        access(1, 32'h0000_0108, 32'h1234_5678, "R7");  // write hit, dirty
        access(0, 32'h0000_0108, '0, "R7");
        access(0, 32'h0000_0300, '0, "R6");   // evicts clean LRU line (R9)
        access(0, 32'h0000_0200, '0, "R6");   // evicts dirty line (R8)
        access(1, 32'h0000_0404, 32'hCAFE_F00D, "R10"); // write miss allocates
        access(0, 32'h0000_0404, '0, "R10");
        access(0, 32'h0000_0400, '0, "R10");
        access(0, 32'h0000_0108, '0, "R8");   // written-back data returns

        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            a = ((($urandom % 4) + 1) << 8) | (($urandom % 4) << 5) | (($urandom % 8) << 2);
            access(bit'($urandom % 2), a, $urandom, "R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule